// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a processor that keeps procedure contexts in hardware. Software always sees 32 registers. The lowest eight are shared by every procedure. The upper 24 belong to the active window, which has three groups of eight: outgoing arguments, private locals and incoming arguments. A window pointer picks the active window inside a circular physical array of `8 + 16*NWIN` registers.

A save strobe moves the pointer down by one window, and a restore strobe moves it up by one. Neighbouring windows share eight physical registers, so the values the caller places in its outgoing group appear in the callee's incoming group without any copy. A mask marks windows that are still occupied by older contexts. A move onto a marked window is refused and raises a trap, so that handler software can spill or fill that window before the move is retried.

The file has two combinational read ports and one write port. All register accesses in a cycle use the pointer value from before any move in that cycle.

Top module: `regwin_file`

## Requirements
- R1: After reset the window pointer is 0 and the invalid mask has only bit 1 set (the mask value is 2).
- R2: Visible registers 0–7 address the same eight physical registers whatever the window pointer is.
- R3: A save with its target window (pointer−1, wrapping from 0 to NWIN−1) unmarked in the mask sets the pointer to that target at the next clock edge.
- R4: A restore with its target window (pointer+1, wrapping from NWIN−1 to 0) unmarked in the mask sets the pointer to that target at the next clock edge.
- R5: A save whose target window has its mask bit set drives `ovf_trap` high in the same cycle, and the pointer keeps its value.
- R6: A restore whose target window has its mask bit set drives `unf_trap` high in the same cycle, and the pointer keeps its value.
- R7: Visible registers 8–15 (outgoing) of window w are the same storage as visible registers 24–31 (incoming) of window w−1 mod NWIN. Within any window, outgoing register 8+i maps to physical 8+((16w+i) mod 16·NWIN) and incoming register 24+i maps to physical 8+((16(w+1)+i) mod 16·NWIN).
- R8: Visible registers 16–23 (locals) of window w map to physical 8+16w+8+i, so they are shared with no other window and with no global register.
- R9: When a read port addresses the physical register that is being written in the same cycle, the port returns the write data (write-first).
- R10: When save and restore are asserted together, neither trap is raised and the pointer does not change.
- R11: When `mask_we` is high at a clock edge, the mask is loaded from `mask_din`, and the new value is visible on `mask` after that edge. Traps in that cycle use the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_addr | input | 5 | Read port A visible register number |
| ra_data | output | W | Read port A data |
| rb_addr | input | 5 | Read port B visible register number |
| rb_data | output | W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write visible register number |
| wr_data | input | W | Write data |
| save | input | 1 | Move to the callee window (pointer − 1) |
| restore | input | 1 | Move back to the caller window (pointer + 1) |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_din | input | NWIN | New mask value |
| mask | output | NWIN | Current invalid-window mask |
| cwp | output | 5 | Current window pointer, zero-extended |
| ovf_trap | output | 1 | Save refused because its target window is marked |
| unf_trap | output | 1 | Restore refused because its target window is marked |

## Verification
A four-window configuration is used. Every visible register is written in every window in turn, and then all 32 registers are read back from every window on both ports. Because later windows overwrite the storage they share with earlier ones, this sweep tells a correct overlap apart from aliasing that is missing or added, and it also tells a correct global mapping apart from a windowed one. Every one of the 16 masks is then combined with save and restore from each pointer position. This separates traps on the target window from traps on the current window, and it shows whether the pointer wraps. Short directed sequences cover the reset state, the out-to-in handoff across a save, simultaneous save and restore, and the same-cycle write bypass.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int NWIN = 8,
  parameter int W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      ra_addr,
  output logic [W-1:0]    ra_data,
  input  logic [4:0]      rb_addr,
  output logic [W-1:0]    rb_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic            save,
  input  logic            restore,
  input  logic            mask_we,
  input  logic [NWIN-1:0] mask_din,
  output logic [NWIN-1:0] mask,
  output logic [4:0]      cwp,
  output logic            ovf_trap,
  output logic            unf_trap
);
  localparam int PW    = $clog2(NWIN);
  localparam int NPHYS = 8 + 16 * NWIN;
  localparam int AW    = $clog2(NPHYS);

  logic [PW-1:0]   ptr_q;
  logic [PW-1:0]   ptr_dn, ptr_up;
  logic [NWIN-1:0] mask_q;
  logic [W-1:0]    rf [NPHYS];
  logic [AW-1:0]   wa_p, ra_p, rb_p;

  function automatic logic [AW-1:0] phys(input logic [PW-1:0] w, input logic [4:0] r);
    int slot;
    if (r[4:3] == 2'd0) return AW'(r);
    case (r[4:3])
      2'd1:    slot = int'(w) * 16 + int'(r[2:0]);
      2'd2:    slot = int'(w) * 16 + 8 + int'(r[2:0]);
      default: slot = (int'(w) + 1) * 16 + int'(r[2:0]);
    endcase
    if (slot >= 16 * NWIN) slot = slot - 16 * NWIN;
    return AW'(8 + slot);
  endfunction

  assign ptr_dn = (ptr_q == '0) ? PW'(NWIN - 1) : ptr_q - 1'b1;
  assign ptr_up = (ptr_q == PW'(NWIN - 1)) ? '0 : ptr_q + 1'b1;

  assign ovf_trap = save & ~restore & mask_q[ptr_dn];
  assign unf_trap = restore & ~save & mask_q[ptr_up];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mask_q <= NWIN'(2);
    end else begin
      if (save && !restore && !ovf_trap) ptr_q <= ptr_dn;
      else if (restore && !save && !unf_trap) ptr_q <= ptr_up;
      if (mask_we) mask_q <= mask_din;
    end
  end

  assign wa_p = phys(ptr_q, wr_addr);
  assign ra_p = phys(ptr_q, ra_addr);
  assign rb_p = phys(ptr_q, rb_addr);

  always_ff @(posedge clk) begin
    if (wr_en) rf[wa_p] <= wr_data;
  end

  assign ra_data = (wr_en && wa_p == ra_p) ? wr_data : rf[ra_p];
  assign rb_data = (wr_en && wa_p == rb_p) ? wr_data : rf[rb_p];

  assign mask = mask_q;
  assign cwp  = 5'(ptr_q);

  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NWIN);

  p_save_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (save && !restore && !ovf_trap) |=>
      ptr_q == (($past(ptr_q) == '0) ? PW'(NWIN - 1) : $past(ptr_q) - 1'b1));

  p_restore_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !save && !unf_trap) |=>
      ptr_q == (($past(ptr_q) == PW'(NWIN - 1)) ? PW'(0) : $past(ptr_q) + 1'b1));

  p_no_move_on_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |=> $stable(ptr_q));

  p_no_move_on_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |=> $stable(ptr_q));

  p_both_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (save && restore) |=> $stable(ptr_q));

  p_traps_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_trap && unf_trap));

  p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(mask_din));

  p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: tb/regwin_file_test.sv
module regwin_file_test;
  localparam int N = 4;
  localparam int W = 16;
  localparam int NP = 8 + 16 * N;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] ra_addr = '0, rb_addr = '0, wr_addr = '0;
  logic [W-1:0] ra_data, rb_data, wr_data = '0;
  logic wr_en = 1'b0, save = 1'b0, restore = 1'b0, mask_we = 1'b0;
  logic [N-1:0] mask_din = '0, mask;
  logic [4:0] cwp;
  logic ovf_trap, unf_trap;

  int tests = 0, fails = 0;
  int cwp_m = 0;
  logic [N-1:0] mask_m = '0;
  logic [W-1:0] mem_m [NP];

  regwin_file #(.NWIN(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save(save), .restore(restore),
    .mask_we(mask_we), .mask_din(mask_din), .mask(mask),
    .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
  );

  always #5 clk = ~clk;

  function automatic int pmap(int w, int r);
    if (r < 8)  return r;
    if (r < 16) return 8 + ((16 * w + r - 8) % (16 * N));
    if (r < 24) return 8 + 16 * w + 8 + (r - 16);
    return 8 + ((16 * (w + 1) + r - 24) % (16 * N));
  endfunction

  function automatic int dn(int c); return (c == 0) ? N - 1 : c - 1; endfunction
  function automatic int up(int c); return (c == N - 1) ? 0 : c + 1; endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_save;
    bit t;
    t = mask_m[dn(cwp_m)];
    save = 1'b1; #1;
    chk(t ? "R5 ovf" : "R3 ovf", int'(ovf_trap), int'(t));
    chk("R5 unf", int'(unf_trap), 0);
    tick; save = 1'b0;
    if (!t) cwp_m = dn(cwp_m);
    chk(t ? "R5 cwp" : "R3 cwp", int'(cwp), cwp_m);
  endtask

  task automatic do_restore;
    bit t;
    t = mask_m[up(cwp_m)];
    restore = 1'b1; #1;
    chk(t ? "R6 unf" : "R4 unf", int'(unf_trap), int'(t));
    chk("R6 ovf", int'(ovf_trap), 0);
    tick; restore = 1'b0;
    if (!t) cwp_m = up(cwp_m);
    chk(t ? "R6 cwp" : "R4 cwp", int'(cwp), cwp_m);
  endtask

  task automatic load_mask(logic [N-1:0] m);
    mask_we = 1'b1; mask_din = m;
    tick; mask_we = 1'b0;
    mask_m = m;
    chk("R11 mask", int'(mask), int'(m));
  endtask

  task automatic wr(int r, logic [W-1:0] v);
    wr_en = 1'b1; wr_addr = 5'(r); wr_data = v;
    tick; wr_en = 1'b0;
    mem_m[pmap(cwp_m, r)] = v;
  endtask

  task automatic goto_win(int w);
    while (cwp_m != w) do_restore;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end

  initial begin
    repeat (2) tick;
    rst_n = 1'b1;
    tick;
    chk("R1 cwp", int'(cwp), 0);
    chk("R1 mask", int'(mask), 2);
    mask_m = N'(2);

    do_restore;
    do_save;
    do_save;
    do_save;
    do_restore;
    do_restore;

    load_mask('0);
    save = 1'b1; restore = 1'b1; #1;
    chk("R10 ovf", int'(ovf_trap), 0);
    chk("R10 unf", int'(unf_trap), 0);
    tick; save = 1'b0; restore = 1'b0;
    chk("R10 cwp", int'(cwp), cwp_m);

    for (int w = 0; w < N; w++) begin
      goto_win(w);
      for (int r = 0; r < 32; r++) wr(r, W'(w * 293 + r * 17 + 5));
    end
    for (int w = 0; w < N; w++) begin
      goto_win(w);
      for (int r = 0; r < 32; r++) begin
        ra_addr = 5'(r); rb_addr = 5'(31 - r); #1;
        chk(r < 8 ? "R2 port A" : (r >= 16 && r < 24) ? "R8 port A" : "R7 port A",
            int'(ra_data), int'(mem_m[pmap(w, r)]));
        chk((31 - r) < 8 ? "R2 port B" : (31 - r >= 16 && 31 - r < 24) ? "R8 port B" : "R7 port B",
            int'(rb_data), int'(mem_m[pmap(w, 31 - r)]));
      end
    end

    goto_win(2);
    for (int i = 0; i < 8; i++) wr(8 + i, W'(16'hA500 + i));
    do_save;
    for (int i = 0; i < 8; i++) begin
      ra_addr = 5'(24 + i); #1;
      chk("R7 handoff", int'(ra_data), 16'hA500 + i);
    end

    wr_en = 1'b1; wr_addr = 5'd17; wr_data = 16'h3C3C;
    ra_addr = 5'd17; rb_addr = 5'd18; #1;
    chk("R9 bypass", int'(ra_data), 16'h3C3C);
    chk("R9 other", int'(rb_data), int'(mem_m[pmap(cwp_m, 18)]));
    tick; wr_en = 1'b0;
    mem_m[pmap(cwp_m, 17)] = 16'h3C3C; #1;
    chk("R9 stored", int'(ra_data), 16'h3C3C);

    mask_we = 1'b1; mask_din = '1; save = 1'b1; #1;
    chk("R11 old mask", int'(ovf_trap), int'(mask_m[dn(cwp_m)]));
    tick; mask_we = 1'b0; save = 1'b0;
    cwp_m = dn(cwp_m); mask_m = '1;
    chk("R11 cwp", int'(cwp), cwp_m);
    chk("R11 new", int'(mask), int'(mask_m));

    for (int m = 0; m < (1 << N); m++) begin
      for (int k = 0; k < N; k++) begin
        load_mask(N'(m));
        do_save;
        do_restore;
        load_mask('0);
        do_restore;
      end
    end

    summary;
  end
endmodule